// File: doc/BRIEF.md
# Split-Capable Auto-Reload Timer with Capture

This block is a 16-bit up-counter for a microcontroller peripheral bus. A byte-wide register port gives access to a control byte, the two count bytes and the two reload bytes. Counting advances on a single-cycle tick input, which stands in for whatever clock source and prescaler the system supplies. In unsplit mode the count is one 16-bit value that reloads from the 16-bit reload pair when it wraps. In split mode the two bytes are separate 8-bit counters, each with its own reload byte.

Setting the capture enable makes the reload pair act as a capture register. A strobe on the capture input copies the live count into it and raises the high flag so that an interrupt follows. While capture is enabled, an overflow wraps the counter to zero. There are two overflow flags: one for high-side overflow and one for every low-byte wrap. Both stay set until software clears them. The interrupt request combines the high flag, gated by a system interrupt enable input, with the low flag, gated by its own enable bit in the control byte.

Top module: `split_reload_timer`

## Requirements
- R1: After reset every register reads 0x00 and irq_o is 0.
- R2: The register addresses are 0 for control, 1 for count low, 2 for count high, 3 for reload low and 4 for reload high; all five can be written and read back. The control bits are: 7 high flag, 6 low flag, 5 low-byte interrupt enable, 4 capture enable, 3 split, 2 run, 1 read-only (always reads 0, ignores writes), 0 plain read/write.
- R3: In unsplit mode (split=0) the 16-bit count rises by one on each tick while run=1. It holds when run=0 or when no tick arrives.
- R4: In unsplit mode a tick at count 0xFFFF sets the high flag and loads the 16-bit reload value.
- R5: A low-byte wrap (0xFF to 0x00) sets the low flag in both modes. In unsplit mode a low-byte wrap that is not a full wrap carries into the high byte and does not reload.
- R6: In split mode the low byte counts on every tick whatever the run bit is. At 0xFF it loads the low reload byte and sets the low flag.
- R7: In split mode the high byte counts on a tick only when run=1. At 0xFF it loads the high reload byte and sets the high flag.
- R8: The flags stay set until a control write puts 0 in them. If a hardware set and a software clear fall in the same cycle, the flag ends up set.
- R9: With capture enabled, a capture strobe copies the current count into the reload pair and sets the high flag. Overflows then wrap to 0x00 instead of reloading. With capture disabled the strobe has no effect.
- R10: irq_o is (irq_en_i AND high flag) OR (low-byte interrupt enable AND low flag).
- R11: A write to either count byte loads that byte at once and suppresses counting and flag setting from a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| tick_i | input | 1 | Count enable pulse |
| capture_i | input | 1 | Capture strobe |
| irq_en_i | input | 1 | System enable for the high-flag interrupt |
| irq_o | output | 1 | Interrupt request |

## Verification
The count bytes and flags can be read directly, so a wrong carry, reload or gating decision shows at the port on the first tick after it happens. The bench sweeps unsplit and split modes through several reload values, with the run bit off and then on. After every tick it compares the count and flag state against an arithmetic model in the bench. A wrong capture copy or interrupt term shows on the next read of the reload bytes or at once on irq_o.

// File: rtl/srt_pkg.sv
package srt_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd1;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd2;
  localparam logic [ADDR_W-1:0] A_RLD_LO = 3'd3;
  localparam logic [ADDR_W-1:0] A_RLD_HI = 3'd4;

  localparam int unsigned B_FLAG_HI = 7;
  localparam int unsigned B_FLAG_LO = 6;
  localparam int unsigned B_LO_IE   = 5;
  localparam int unsigned B_CAP_EN  = 4;
  localparam int unsigned B_SPLIT   = 3;
  localparam int unsigned B_RUN     = 2;
  localparam int unsigned B_RO      = 1;
  localparam int unsigned B_SPARE   = 0;

  typedef struct packed {
    logic flag_hi;
    logic flag_lo;
    logic lo_ie;
    logic cap_en;
    logic split;
    logic run;
    logic spare;
  } ctrl_t;
endpackage

// File: rtl/srt_byte_cnt.sv
module srt_byte_cnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] reload_i,
  input  logic         use_reload_i,
  output logic [W-1:0] cnt_o,
  output logic         at_max_o
);
  localparam logic [W-1:0] MAX = {W{1'b1}};

  logic [W-1:0] cnt_q, cnt_d;

  assign at_max_o = (cnt_q == MAX);
  assign cnt_o    = cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (wr_i)             cnt_d = wdata_i;
    else if (step_i) begin
      if (!at_max_o)      cnt_d = cnt_q + W'(1);
      else if (use_reload_i) cnt_d = reload_i;
      else                cnt_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  AST_STEP_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !wr_i && !at_max_o) |=> (cnt_o == W'($past(cnt_o) + W'(1)))); // R3

  AST_WRAP_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !wr_i && at_max_o && use_reload_i) |=> (cnt_o == $past(reload_i))); // R4

  AST_WRAP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !wr_i && at_max_o && !use_reload_i) |=> (cnt_o == '0)); // R9
endmodule

// File: rtl/srt_ctrl_regs.sv
module srt_ctrl_regs
  import srt_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      wdata_i,
  input  logic              set_hi_i,
  input  logic              set_lo_i,
  input  logic              capture_i,
  input  logic [2*W-1:0]    cnt_i,
  output ctrl_t             ctrl_o,
  output logic [2*W-1:0]    rld_o
);
  ctrl_t          ctrl_q;
  logic [W-1:0]   rld_lo_q, rld_hi_q;
  logic           wr_ctrl, cap_fire, hi_set;
  logic           unused_ro;

  assign unused_ro = wdata_i[B_RO];
  assign wr_ctrl   = wr_en_i && (addr_i == A_CTRL);
  assign cap_fire  = ctrl_q.cap_en && capture_i;
  assign hi_set    = set_hi_i || cap_fire;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else begin
      // hardware set dominates a same-cycle software clear
      ctrl_q.flag_hi <= (wr_ctrl ? wdata_i[B_FLAG_HI] : ctrl_q.flag_hi) | hi_set;
      ctrl_q.flag_lo <= (wr_ctrl ? wdata_i[B_FLAG_LO] : ctrl_q.flag_lo) | set_lo_i;
      if (wr_ctrl) begin
        ctrl_q.lo_ie  <= wdata_i[B_LO_IE];
        ctrl_q.cap_en <= wdata_i[B_CAP_EN];
        ctrl_q.split  <= wdata_i[B_SPLIT];
        ctrl_q.run    <= wdata_i[B_RUN];
        ctrl_q.spare  <= wdata_i[B_SPARE];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rld_lo_q <= '0;
      rld_hi_q <= '0;
    end else if (cap_fire) begin
      rld_lo_q <= cnt_i[W-1:0];
      rld_hi_q <= cnt_i[2*W-1:W];
    end else if (wr_en_i) begin
      if (addr_i == A_RLD_LO) rld_lo_q <= wdata_i;
      if (addr_i == A_RLD_HI) rld_hi_q <= wdata_i;
    end
  end

  assign ctrl_o = ctrl_q;
  assign rld_o  = {rld_hi_q, rld_lo_q};

  AST_FLAG_HI_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.flag_hi && !wr_ctrl) |=> ctrl_q.flag_hi); // R8

  AST_FLAG_LO_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.flag_lo && !wr_ctrl) |=> ctrl_q.flag_lo); // R8

  AST_CAPTURE_COPY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.cap_en && capture_i) |=> (rld_o == $past(cnt_i) && ctrl_q.flag_hi)); // R9
endmodule

// File: rtl/split_reload_timer.sv
module split_reload_timer
  import srt_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      wdata_i,
  output logic [W-1:0]      rdata_o,
  input  logic              tick_i,
  input  logic              capture_i,
  input  logic              irq_en_i,
  output logic              irq_o
);
  localparam int unsigned NB = 2;

  ctrl_t          ctrl;
  logic [2*W-1:0] rld, cnt;
  logic [NB-1:0]  step, wr_byte, at_max, use_rld;
  logic           hold, full_wrap, set_hi, set_lo;

  assign wr_byte[0] = wr_en_i && (addr_i == A_CNT_LO);
  assign wr_byte[1] = wr_en_i && (addr_i == A_CNT_HI);
  assign hold       = |wr_byte;

  // low byte runs free in split mode
  assign step[0]   = tick_i && !hold && (ctrl.split || ctrl.run);
  assign step[1]   = ctrl.split ? (tick_i && !hold && ctrl.run) : (step[0] && at_max[0]);
  assign full_wrap = !ctrl.split && step[0] && at_max[0] && at_max[1];

  assign use_rld[0] = !ctrl.cap_en && (ctrl.split || at_max[1]);
  assign use_rld[1] = !ctrl.cap_en;

  assign set_lo = step[0] && at_max[0];
  assign set_hi = ctrl.split ? (step[1] && at_max[1]) : full_wrap;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    srt_byte_cnt #(.W(W)) u_cnt (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .step_i       (step[b]),
      .wr_i         (wr_byte[b]),
      .wdata_i      (wdata_i),
      .reload_i     (rld[b*W +: W]),
      .use_reload_i (use_rld[b]),
      .cnt_o        (cnt[b*W +: W]),
      .at_max_o     (at_max[b])
    );
  end

  srt_ctrl_regs #(.W(W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .set_hi_i  (set_hi),
    .set_lo_i  (set_lo),
    .capture_i (capture_i),
    .cnt_i     (cnt),
    .ctrl_o    (ctrl),
    .rld_o     (rld)
  );

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_CTRL: begin
        rdata_o[B_FLAG_HI] = ctrl.flag_hi;
        rdata_o[B_FLAG_LO] = ctrl.flag_lo;
        rdata_o[B_LO_IE]   = ctrl.lo_ie;
        rdata_o[B_CAP_EN]  = ctrl.cap_en;
        rdata_o[B_SPLIT]   = ctrl.split;
        rdata_o[B_RUN]     = ctrl.run;
        rdata_o[B_SPARE]   = ctrl.spare;
      end
      A_CNT_LO: rdata_o = cnt[W-1:0];
      A_CNT_HI: rdata_o = cnt[2*W-1:W];
      A_RLD_LO: rdata_o = rld[W-1:0];
      A_RLD_HI: rdata_o = rld[2*W-1:W];
      default:  rdata_o = '0;
    endcase
  end

  assign irq_o = (irq_en_i && ctrl.flag_hi) || (ctrl.lo_ie && ctrl.flag_lo);

  AST_RUN_OFF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl.split && !ctrl.run && !hold) |=> $stable(cnt)); // R3

  AST_SPLIT_LO_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl.split && tick_i && !hold && !at_max[0]) |=> (cnt[W-1:0] == W'($past(cnt[W-1:0]) + W'(1)))); // R6

  AST_WRITE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_byte[0] |=> (cnt[W-1:0] == $past(wdata_i))); // R11

  AST_FULL_WRAP_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_wrap |=> (ctrl.flag_hi && ctrl.flag_lo)); // R4
endmodule

// File: tb/sim_split_reload_timer.sv
module sim_split_reload_timer;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [2:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       tick_i = 1'b0;
  logic       capture_i = 1'b0;
  logic       irq_en_i = 1'b0;
  logic       irq_o;

  localparam logic [7:0] C_FH = 8'h80, C_FL = 8'h40, C_LOIE = 8'h20, C_CAP = 8'h10,
                         C_SPLIT = 8'h08, C_RUN = 8'h04;

  int n_chk = 0;
  int n_err = 0;

  // bench model
  logic [7:0] m_lo, m_hi, m_rlo, m_rhi;
  logic       m_fh, m_fl, m_split, m_run, m_cap;

  always #2.5 clk_i = ~clk_i;

  split_reload_timer u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .tick_i(tick_i), .capture_i(capture_i),
    .irq_en_i(irq_en_i), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input bit we, input logic [2:0] a, input logic [7:0] d,
                     input bit tk, input bit cp);
    @(negedge clk_i);
    wr_en_i = we; addr_i = a; wdata_i = d; tick_i = tk; capture_i = cp;
    @(negedge clk_i);
    wr_en_i = 1'b0; tick_i = 1'b0; capture_i = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    cyc(1'b1, a, d, 1'b0, 1'b0);
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    addr_i = a;
    #1;
    v = rdata_o;
  endtask

  task automatic set_ctrl(input logic [7:0] c);
    wr(3'd0, c);
    m_fh = c[7]; m_fl = c[6]; m_cap = c[4]; m_split = c[3]; m_run = c[2];
  endtask

  task automatic model_tick();
    if (m_split) begin
      if (m_lo == 8'hFF) begin m_fl = 1'b1; m_lo = m_cap ? 8'h00 : m_rlo; end
      else m_lo = m_lo + 8'd1;
      if (m_run) begin
        if (m_hi == 8'hFF) begin m_fh = 1'b1; m_hi = m_cap ? 8'h00 : m_rhi; end
        else m_hi = m_hi + 8'd1;
      end
    end else if (m_run) begin
      if (m_lo == 8'hFF) m_fl = 1'b1;
      if ({m_hi, m_lo} == 16'hFFFF) begin
        m_fh = 1'b1;
        {m_hi, m_lo} = m_cap ? 16'h0000 : {m_rhi, m_rlo};
      end else {m_hi, m_lo} = {m_hi, m_lo} + 16'd1;
    end
  endtask

  task automatic chk_state(input string req);
    logic [7:0] lo, hi, c;
    rd(3'd1, lo); rd(3'd2, hi); rd(3'd0, c);
    chk(req, {hi, lo}, {m_hi, m_lo});
    chk(req, {14'd0, c[7:6]}, {14'd0, m_fh, m_fl});
  endtask

  task automatic finish_up();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #(5ns * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    logic [7:0] v;
    logic [7:0] rlo_set [4];
    rlo_set[0] = 8'h00; rlo_set[1] = 8'h80; rlo_set[2] = 8'hF0; rlo_set[3] = 8'hFF;

    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v);
      chk("R1 reset reg", {8'd0, v}, 16'h0000);
    end
    chk("R1 irq", {15'd0, irq_o}, 16'h0);

    // R2 map and readback
    wr(3'd0, 8'h02); rd(3'd0, v); chk("R2 ro bit", {8'd0, v}, 16'h00);
    wr(3'd0, 8'h3D); rd(3'd0, v); chk("R2 ctrl rw", {8'd0, v}, 16'h3D);
    wr(3'd0, 8'h00);
    wr(3'd3, 8'hA5); rd(3'd3, v); chk("R2 rld lo", {8'd0, v}, 16'hA5);
    wr(3'd4, 8'h5A); rd(3'd4, v); chk("R2 rld hi", {8'd0, v}, 16'h5A);
    wr(3'd1, 8'hC3); rd(3'd1, v); chk("R2 cnt lo", {8'd0, v}, 16'hC3);
    wr(3'd2, 8'h3C); rd(3'd2, v); chk("R2 cnt hi", {8'd0, v}, 16'h3C);

    // R3 gating in unsplit mode
    m_lo = 8'hC3; m_hi = 8'h3C; m_rlo = 8'hA5; m_rhi = 8'h5A;
    set_ctrl(8'h00);
    for (int i = 0; i < 4; i++) cyc(1'b0, 3'd0, 8'h0, 1'b1, 1'b0);
    chk_state("R3 run off holds");
    set_ctrl(C_RUN);
    for (int i = 0; i < 4; i++) cyc(1'b0, 3'd0, 8'h0, 1'b0, 1'b0);
    chk_state("R3 no tick holds");
    for (int i = 0; i < 5; i++) begin
      cyc(1'b0, 3'd0, 8'h0, 1'b1, 1'b0); model_tick();
    end
    chk_state("R3 counts");

    // R4 R5 sweep through a carry and a full wrap
    wr(3'd3, 8'h34); wr(3'd4, 8'h12); m_rlo = 8'h34; m_rhi = 8'h12;
    wr(3'd1, 8'hF0); wr(3'd2, 8'hFE); m_lo = 8'hF0; m_hi = 8'hFE;
    for (int i = 0; i < 300; i++) begin
      cyc(1'b0, 3'd0, 8'h0, 1'b1, 1'b0); model_tick();
      chk_state("R4 R5 unsplit sweep");
    end

    // R10 interrupt terms
    irq_en_i = 1'b0; set_ctrl(C_RUN | C_FH); #1;
    chk("R10 hi gated off", {15'd0, irq_o}, 16'h0);
    irq_en_i = 1'b1; #1;
    chk("R10 hi enabled", {15'd0, irq_o}, 16'h1);
    irq_en_i = 1'b0; set_ctrl(C_FL); #1;
    chk("R10 lo no enable", {15'd0, irq_o}, 16'h0);
    set_ctrl(C_FL | C_LOIE); #1;
    chk("R10 lo enabled", {15'd0, irq_o}, 16'h1);

    // R8 sticky, clear, collision
    set_ctrl(C_FH | C_FL);
    repeat (3) cyc(1'b0, 3'd0, 8'h0, 1'b0, 1'b0);
    rd(3'd0, v); chk("R8 sticky", {14'd0, v[7:6]}, 16'h3);
    set_ctrl(8'h00); rd(3'd0, v); chk("R8 clear", {14'd0, v[7:6]}, 16'h0);
    wr(3'd1, 8'hFF); wr(3'd2, 8'hFF);
    set_ctrl(C_RUN | C_FH);
    cyc(1'b1, 3'd0, C_RUN, 1'b1, 1'b0);
    rd(3'd0, v); chk("R8 set beats clear", {14'd0, v[7:6]}, 16'h3);
    rd(3'd1, v); chk("R4 reload lo", {8'd0, v}, 16'h34);

    // R6 R7 split sweep
    foreach (rlo_set[k]) begin
      wr(3'd3, rlo_set[k]); wr(3'd4, 8'hFC); m_rlo = rlo_set[k]; m_rhi = 8'hFC;
      wr(3'd1, 8'hF8); wr(3'd2, 8'hF9); m_lo = 8'hF8; m_hi = 8'hF9;
      set_ctrl(C_SPLIT);
      for (int i = 0; i < 40; i++) begin
        cyc(1'b0, 3'd0, 8'h0, 1'b1, 1'b0); model_tick();
        chk_state("R6 split low free");
      end
      set_ctrl(C_SPLIT | C_RUN);
      for (int i = 0; i < 60; i++) begin
        cyc(1'b0, 3'd0, 8'h0, 1'b1, 1'b0); model_tick();
        chk_state("R7 split high run");
      end
    end

    // R9 capture
    wr(3'd3, 8'h11); wr(3'd4, 8'h22);
    set_ctrl(8'h00);
    wr(3'd1, 8'h56); wr(3'd2, 8'h34);
    cyc(1'b0, 3'd0, 8'h0, 1'b0, 1'b1);
    rd(3'd3, v); chk("R9 disabled ignored", {8'd0, v}, 16'h11);
    rd(3'd0, v); chk("R9 disabled no flag", {15'd0, v[7]}, 16'h0);
    set_ctrl(C_CAP | C_RUN);
    cyc(1'b0, 3'd0, 8'h0, 1'b0, 1'b1);
    rd(3'd3, v); chk("R9 capture lo", {8'd0, v}, 16'h56);
    rd(3'd4, v); chk("R9 capture hi", {8'd0, v}, 16'h34);
    rd(3'd0, v); chk("R9 capture flag", {15'd0, v[7]}, 16'h1);
    wr(3'd1, 8'hFF); wr(3'd2, 8'hFF);
    cyc(1'b0, 3'd0, 8'h0, 1'b1, 1'b0);
    rd(3'd1, v); chk("R9 wrap zero lo", {8'd0, v}, 16'h00);
    rd(3'd2, v); chk("R9 wrap zero hi", {8'd0, v}, 16'h00);

    // R11 write beats tick
    set_ctrl(C_RUN);
    wr(3'd1, 8'hFF); wr(3'd2, 8'h07);
    cyc(1'b1, 3'd1, 8'hFF, 1'b1, 1'b0);
    rd(3'd1, v); chk("R11 lo written", {8'd0, v}, 16'hFF);
    rd(3'd2, v); chk("R11 hi no carry", {8'd0, v}, 16'h07);
    rd(3'd0, v); chk("R11 no flag", {14'd0, v[7:6]}, 16'h0);

    finish_up();
  end
endmodule